// File: doc/BRIEF.md
# Monochrome Color Expansion Unit

This block turns a stream of one-bit-per-pixel source bytes into colored destination pixels of 1, 2, 3 or 4 bytes. Each source bit picks between a foreground and a background color. The low byte of each color comes from a base register, and the upper bytes come from separately written extension bytes. A blit is described by a pixel-width code, a width and a height (each given as count minus one), and four mode flags: transparent, invert, pattern and double-word granularity. The blit starts with a one-cycle `start` pulse.

In opaque mode every pixel is written. In transparent mode only the pixels of one bit value are written, and the others come out with all byte enables low. In pattern mode the unit first takes an 8-byte monochrome tile and then tiles it over the whole rectangle without reading more source. Results come out as one registered pixel per cycle, with its coordinates, up to four data bytes (low byte in bits 7:0), and a per-byte write enable. The raster operation that follows is plain source copy.

Top module: `mono_expand`

## Requirements
- R1: `cfg_pxw` code 0,1,2,3 selects pixels of 1,2,3,4 bytes. For every output pixel, `out_be` bits at or above the pixel byte count are 0.
- R2: Foreground byte 0 is `fg_base`. Byte k (k = 1..3) is `fg_ext[8k-1:8k-8]` when k is below the pixel byte count, and 0 otherwise. The background is built the same way from `bg_base`/`bg_ext`. Byte 0 sits in `out_data[7:0]`, byte 1 in [15:8], byte 2 in [23:16], byte 3 in [31:24]. A 3-byte pixel therefore comes out as low, middle, high.
- R3: When `cfg_transp`=0 (opaque), every pixel has all enables of its width set. Bit 1 gives the foreground and bit 0 the background. `cfg_invert` has no effect.
- R4: When `cfg_transp`=1 and `cfg_invert`=0, pixels with bit 1 are written in the foreground and pixels with bit 0 have `out_be`=0. When `cfg_invert`=1, pixels with bit 0 are written in the background and pixels with bit 1 have `out_be`=0.
- R5: Pixels leave in raster order: x from 0 to width-1 within a line, and lines from 0 to height-1, reported on `out_x`/`out_y`. Bit 7 of a source byte is the leftmost of its 8 pixels.
- R6: Without pattern and without double-word granularity, each line uses exactly ceil(width/8) source bytes. Every line starts on a fresh byte, and unused low bits of a line's last byte are dropped.
- R7: With `cfg_dword`=1 (non-pattern), each line uses 4*ceil(width/32) source bytes. Bytes beyond ceil(width/8) are consumed and discarded.
- R8: With `cfg_pattern`=1, the first 8 source bytes are tile rows 0 to 7 and no more source is consumed. Pixel (x,y) uses row y mod 8, bit 7-(x mod 8).
- R9: Configuration, colors and geometry are captured when `start` is seen while idle. A `start` pulse or a configuration change while busy has no effect on the running blit.
- R10: A source byte is taken only in a cycle with `src_valid` and `src_ready` both high. Gaps in `src_valid` lose no data. `src_ready` is low while idle.
- R11: After reset `busy`, `src_ready` and `out_valid` are 0, and `out_be` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a blit (taken only when idle) |
| cfg_pxw | input | 2 | Pixel width code, bytes minus one |
| cfg_transp | input | 1 | Transparent mode |
| cfg_invert | input | 1 | Draw zero bits with background in transparent mode |
| cfg_pattern | input | 1 | 8x8 tile mode |
| cfg_dword | input | 1 | Source line padded to 32-pixel groups |
| cfg_wm1 | input | W_BITS | Width in pixels minus one |
| cfg_hm1 | input | H_BITS | Height in lines minus one |
| fg_base | input | 8 | Foreground byte 0 |
| fg_ext | input | 24 | Foreground bytes 3..1 |
| bg_base | input | 8 | Background byte 0 |
| bg_ext | input | 24 | Background bytes 3..1 |
| src_data | input | 8 | Monochrome source byte |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Source byte accepted when valid |
| busy | output | 1 | Blit in progress |
| out_valid | output | 1 | Pixel present on outputs |
| out_x | output | W_BITS | Pixel column |
| out_y | output | H_BITS | Pixel line |
| out_data | output | 32 | Pixel bytes, byte 0 lowest |
| out_be | output | 4 | Per-byte write enable |

## Verification
The bench uses widths that are not multiples of 8, so a design that carried leftover bits into the next line would shift every later line. Double-word cases count the source bytes taken: a design that skipped the padding would read the next line's data too early. Pattern blits taller than 8 lines and wider than 8 pixels catch row or column wrap errors, and 3-byte pixels expose a wrong byte order or stray upper bytes. Both invert settings are run in each mode, and a start pulse with changed settings is sent mid-blit, so a design that swapped the drawn bit value or re-latched its setup would write the wrong pixels.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int PXW_BITS  = $clog2(MAX_BYTES);
  localparam int PIX_W     = BYTE_W * MAX_BYTES;
  localparam int EXT_W     = BYTE_W * (MAX_BYTES - 1);
  localparam int COL_BITS  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLOAD = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;

  function automatic logic [MAX_BYTES-1:0] width_mask(input logic [PXW_BITS-1:0] code);
    logic [MAX_BYTES-1:0] m;
    for (int i = 0; i < MAX_BYTES; i++) m[i] = (i <= int'(code));
    return m;
  endfunction
endpackage

// File: rtl/mce_color.sv
module mce_color
  import mce_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [PXW_BITS-1:0] pxw,
  input  logic [BYTE_W-1:0]   base,
  input  logic [EXT_W-1:0]    ext,
  output logic [PIX_W-1:0]    color
);
  logic [PIX_W-1:0] asm_c;

  assign asm_c[BYTE_W-1:0] = base;

  generate
    for (genvar i = 1; i < MAX_BYTES; i++) begin : g_byte
      assign asm_c[i*BYTE_W +: BYTE_W] =
        (pxw >= PXW_BITS'(i)) ? ext[(i-1)*BYTE_W +: BYTE_W] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       color <= '0;
    else if (load) color <= asm_c;
  end
endmodule

// File: rtl/mce_seq.sv
module mce_seq
  import mce_pkg::*;
#(
  parameter int W_BITS   = 12,
  parameter int H_BITS   = 12,
  parameter int PAT_ROWS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_pattern,
  input  logic              cfg_dword,
  input  logic [W_BITS-1:0] cfg_wm1,
  input  logic [H_BITS-1:0] cfg_hm1,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic              busy,
  output logic              start_ok,
  output logic              pix_fire,
  output logic              pix_bit,
  output logic [W_BITS-1:0] pix_x,
  output logic [H_BITS-1:0] pix_y
);
  localparam int PR_BITS = $clog2(PAT_ROWS);

  seq_state_t        state;
  logic [W_BITS-1:0] wm1_q, need_q, need_n, taken_q, x_q;
  logic [H_BITS-1:0] hm1_q, y_q;
  logic              pat_q, have_q;
  logic [BYTE_W-1:0] cur_q, pat_row;
  logic [PR_BITS-1:0] pcnt_q;
  logic [BYTE_W-1:0] pat_mem [PAT_ROWS];
  logic              hs, last_x, last_y, line_short;
  logic [COL_BITS-1:0] col;

  // bytes consumed per source line
  always_comb begin
    if (cfg_dword) need_n = ((cfg_wm1 >> 5) + W_BITS'(1)) << 2;
    else           need_n = (cfg_wm1 >> 3) + W_BITS'(1);
  end

  assign busy       = (state != ST_IDLE);
  assign start_ok   = start && (state == ST_IDLE);
  assign src_ready  = (state == ST_PLOAD) || (state == ST_DRAIN) ||
                      ((state == ST_RUN) && !pat_q && !have_q);
  assign hs         = src_valid && src_ready;
  assign last_x     = (x_q == wm1_q);
  assign last_y     = (y_q == hm1_q);
  assign line_short = (taken_q != need_q);
  assign col        = x_q[COL_BITS-1:0];
  assign pat_row    = pat_mem[y_q[PR_BITS-1:0]];

  assign pix_fire = (state == ST_RUN) && (pat_q || have_q);
  assign pix_bit  = pat_q ? pat_row[~col] : cur_q[~col];
  assign pix_x    = x_q;
  assign pix_y    = y_q;

  // tile storage, no reset so it maps onto distributed/block RAM
  always_ff @(posedge clk) begin
    if (state == ST_PLOAD && hs) pat_mem[pcnt_q] <= src_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wm1_q   <= '0;
      hm1_q   <= '0;
      need_q  <= '0;
      taken_q <= '0;
      x_q     <= '0;
      y_q     <= '0;
      pat_q   <= 1'b0;
      have_q  <= 1'b0;
      cur_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            wm1_q   <= cfg_wm1;
            hm1_q   <= cfg_hm1;
            need_q  <= need_n;
            pat_q   <= cfg_pattern;
            taken_q <= '0;
            x_q     <= '0;
            y_q     <= '0;
            have_q  <= 1'b0;
            pcnt_q  <= '0;
            state   <= cfg_pattern ? ST_PLOAD : ST_RUN;
          end
        end
        ST_PLOAD: begin
          if (hs) begin
            pcnt_q <= pcnt_q + PR_BITS'(1);
            if (pcnt_q == PR_BITS'(PAT_ROWS - 1)) state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!pat_q && !have_q) begin
            if (hs) begin
              cur_q   <= src_data;
              have_q  <= 1'b1;
              taken_q <= taken_q + W_BITS'(1);
            end
          end else begin
            if (last_x) begin
              x_q    <= '0;
              have_q <= 1'b0;
              if (!pat_q && line_short) begin
                state <= ST_DRAIN;
              end else begin
                taken_q <= '0;
                if (last_y) state <= ST_IDLE;
                else        y_q   <= y_q + H_BITS'(1);
              end
            end else begin
              x_q <= x_q + W_BITS'(1);
              if (col == COL_BITS'(BYTE_W - 1)) have_q <= 1'b0;
            end
          end
        end
        ST_DRAIN: begin
          if (hs) begin
            if (taken_q + W_BITS'(1) == need_q) begin
              taken_q <= '0;
              if (last_y) state <= ST_IDLE;
              else begin
                y_q   <= y_q + H_BITS'(1);
                state <= ST_RUN;
              end
            end else begin
              taken_q <= taken_q + W_BITS'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mce_out.sv
module mce_out
  import mce_pkg::*;
#(
  parameter int W_BITS = 12,
  parameter int H_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 cfg_transp,
  input  logic                 cfg_invert,
  input  logic [PXW_BITS-1:0]  cfg_pxw,
  input  logic                 fire,
  input  logic                 bit_in,
  input  logic [W_BITS-1:0]    x_in,
  input  logic [H_BITS-1:0]    y_in,
  input  logic [PIX_W-1:0]     fg,
  input  logic [PIX_W-1:0]     bg,
  output logic                 out_valid,
  output logic [W_BITS-1:0]    out_x,
  output logic [H_BITS-1:0]    out_y,
  output logic [PIX_W-1:0]     out_data,
  output logic [MAX_BYTES-1:0] out_be
);
  logic                 tr_q, inv_q, draw;
  logic [MAX_BYTES-1:0] mask_q;
  logic [PIX_W-1:0]     color;

  always_comb begin
    if (tr_q) begin
      draw  = bit_in ^ inv_q;
      color = inv_q ? bg : fg;
    end else begin
      draw  = 1'b1;
      color = bit_in ? fg : bg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_q   <= 1'b0;
      inv_q  <= 1'b0;
      mask_q <= '0;
    end else if (load) begin
      tr_q   <= cfg_transp;
      inv_q  <= cfg_invert;
      mask_q <= width_mask(cfg_pxw);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_data  <= '0;
      out_be    <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_x    <= x_in;
        out_y    <= y_in;
        out_data <= color;
        out_be   <= draw ? mask_q : '0;
      end else begin
        out_be   <= '0;
      end
    end
  end
endmodule

// File: rtl/mono_expand.sv
module mono_expand
  import mce_pkg::*;
#(
  parameter int W_BITS   = 12,
  parameter int H_BITS   = 12,
  parameter int PAT_ROWS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [PXW_BITS-1:0]  cfg_pxw,
  input  logic                 cfg_transp,
  input  logic                 cfg_invert,
  input  logic                 cfg_pattern,
  input  logic                 cfg_dword,
  input  logic [W_BITS-1:0]    cfg_wm1,
  input  logic [H_BITS-1:0]    cfg_hm1,
  input  logic [BYTE_W-1:0]    fg_base,
  input  logic [EXT_W-1:0]     fg_ext,
  input  logic [BYTE_W-1:0]    bg_base,
  input  logic [EXT_W-1:0]     bg_ext,
  input  logic [BYTE_W-1:0]    src_data,
  input  logic                 src_valid,
  output logic                 src_ready,
  output logic                 busy,
  output logic                 out_valid,
  output logic [W_BITS-1:0]    out_x,
  output logic [H_BITS-1:0]    out_y,
  output logic [PIX_W-1:0]     out_data,
  output logic [MAX_BYTES-1:0] out_be
);
  logic              start_ok, pix_fire, pix_bit;
  logic [W_BITS-1:0] pix_x;
  logic [H_BITS-1:0] pix_y;
  logic [PIX_W-1:0]  fg_c, bg_c;

  mce_color u_fg (
    .clk(clk), .rst(rst), .load(start_ok), .pxw(cfg_pxw),
    .base(fg_base), .ext(fg_ext), .color(fg_c)
  );

  mce_color u_bg (
    .clk(clk), .rst(rst), .load(start_ok), .pxw(cfg_pxw),
    .base(bg_base), .ext(bg_ext), .color(bg_c)
  );

  mce_seq #(.W_BITS(W_BITS), .H_BITS(H_BITS), .PAT_ROWS(PAT_ROWS)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pattern(cfg_pattern), .cfg_dword(cfg_dword),
    .cfg_wm1(cfg_wm1), .cfg_hm1(cfg_hm1),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .busy(busy), .start_ok(start_ok),
    .pix_fire(pix_fire), .pix_bit(pix_bit), .pix_x(pix_x), .pix_y(pix_y)
  );

  mce_out #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_out (
    .clk(clk), .rst(rst), .load(start_ok),
    .cfg_transp(cfg_transp), .cfg_invert(cfg_invert), .cfg_pxw(cfg_pxw),
    .fire(pix_fire), .bit_in(pix_bit), .x_in(pix_x), .y_in(pix_y),
    .fg(fg_c), .bg(bg_c),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .out_data(out_data), .out_be(out_be)
  );
endmodule

// File: rtl/mce_chk.sv
module mce_chk
  import mce_pkg::*;
#(
  parameter int W_BITS = 12,
  parameter int H_BITS = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic [PXW_BITS-1:0]  cfg_pxw,
  input logic                 cfg_transp,
  input logic                 src_ready,
  input logic                 out_valid,
  input logic [W_BITS-1:0]    out_x,
  input logic [H_BITS-1:0]    out_y,
  input logic [MAX_BYTES-1:0] out_be
);
  logic [MAX_BYTES-1:0] mask_q;
  logic                 tr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      tr_q   <= 1'b0;
    end else if (start && !busy) begin
      mask_q <= width_mask(cfg_pxw);
      tr_q   <= cfg_transp;
    end
  end

  // R1
  be_in_width_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_be & ~mask_q) == '0));

  // R3
  opaque_full_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !tr_q) |-> (out_be == mask_q));

  // R4
  be_all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_be == '0 || out_be == mask_q));

  // R5
  raster_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && out_y == $past(out_y)) |->
      (out_x == $past(out_x) + W_BITS'(1)));

  // R10
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !src_ready);

  // R11
  quiet_be_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_be == '0));
endmodule

bind mono_expand mce_chk #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .cfg_pxw(cfg_pxw),
  .cfg_transp(cfg_transp), .src_ready(src_ready), .out_valid(out_valid),
  .out_x(out_x), .out_y(out_y), .out_be(out_be)
);

// File: tb/sim_mono_expand.sv
`timescale 1ns/1ps
module sim_mono_expand;
  localparam int WB = 12;
  localparam int HB = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] cfg_pxw = '0;
  logic cfg_transp = 0, cfg_invert = 0, cfg_pattern = 0, cfg_dword = 0;
  logic [WB-1:0] cfg_wm1 = '0;
  logic [HB-1:0] cfg_hm1 = '0;
  logic [7:0] fg_base = '0, bg_base = '0;
  logic [23:0] fg_ext = '0, bg_ext = '0;
  logic [7:0] src_data = '0;
  logic src_valid = 1'b0;
  logic src_ready, busy, out_valid;
  logic [WB-1:0] out_x;
  logic [HB-1:0] out_y;
  logic [31:0] out_data;
  logic [3:0] out_be;

  always #2.5 clk = ~clk;

  mono_expand #(.W_BITS(WB), .H_BITS(HB)) u0 (.*);

  int nchecks = 0, nerr = 0, seed = 1;
  logic [7:0] src_mem [0:511];
  int src_len = 0, src_idx = 0;
  bit hs_pend = 0, tgl = 0, stall_en = 0;
  int ncap = 0;
  int cap_x [0:1023];
  int cap_y [0:1023];
  logic [31:0] cap_d [0:1023];
  logic [3:0] cap_be [0:1023];

  always @(negedge clk) begin
    if (hs_pend) src_idx++;
    tgl = ~tgl;
    src_valid = (src_idx < src_len) && !(stall_en && tgl);
    src_data  = (src_idx < 512) ? src_mem[src_idx] : 8'h00;
    hs_pend   = src_valid && src_ready;
    if (out_valid && ncap < 1024) begin
      cap_x[ncap] = int'(out_x);
      cap_y[ncap] = int'(out_y);
      cap_d[ncap] = out_data;
      cap_be[ncap] = out_be;
      ncap++;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] build(input logic [7:0] b, input logic [23:0] e, input int nb);
    logic [31:0] c = {e, b};
    for (int k = nb; k < 4; k++) c[k*8 +: 8] = 8'h00;
    return c;
  endfunction

  task automatic run_blit(input string tag, input logic [1:0] pxw, input bit tr, input bit inv,
                          input bit pat, input bit dw, input int w, input int h,
                          input bit stall, input bit poke);
    int need, expc, nb;
    logic [31:0] fgc, bgc;
    logic [3:0] mask;
    seed++;
    for (int i = 0; i < 512; i++)
      src_mem[i] = 8'(((i * 73) + (seed * 29) + ((i >> 3) * 11)) ^ (seed << 2));
    nb   = int'(pxw) + 1;
    mask = 4'((1 << nb) - 1);
    need = dw ? ((w + 31) / 32) * 4 : (w + 7) / 8;
    expc = pat ? 8 : need * h;
    fg_base = 8'(seed * 13 + 1);
    bg_base = 8'(seed * 7 + 90);
    fg_ext  = {8'(seed + 200), 8'(seed * 3 + 17), 8'(seed * 5 + 40)};
    bg_ext  = {8'(seed + 100), 8'(seed * 9 + 3), 8'(seed * 11 + 60)};
    fgc = build(fg_base, fg_ext, nb);
    bgc = build(bg_base, bg_ext, nb);
    src_idx = 0; src_len = expc + 6; ncap = 0; stall_en = stall;
    cfg_pxw = pxw; cfg_transp = tr; cfg_invert = inv; cfg_pattern = pat; cfg_dword = dw;
    cfg_wm1 = WB'(w - 1); cfg_hm1 = HB'(h - 1);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: changed setup and a second start while busy must not matter
      repeat (4) @(negedge clk);
      cfg_pxw = ~pxw; cfg_transp = ~tr; cfg_wm1 = '0; fg_base = ~fg_base; fg_ext = ~fg_ext;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(tag, "pixel count", 32'(ncap), 32'(w * h));
    chk(tag, "source bytes consumed", 32'(src_idx), 32'(expc));
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        int k = y * w + x;
        logic b, dr;
        logic [7:0] sb;
        logic [31:0] col;
        sb = pat ? src_mem[y % 8] : src_mem[y * need + x / 8];
        b  = sb[7 - (x % 8)];
        if (tr) begin dr = b ^ inv; col = inv ? bgc : fgc; end
        else    begin dr = 1'b1;    col = b ? fgc : bgc; end
        if (k < ncap) begin
          chk(tag, "x/y position", 32'((cap_x[k] << 16) | cap_y[k]), 32'((x << 16) | y));
          chk(tag, "byte enables", 32'(cap_be[k]), 32'(dr ? mask : 4'h0));
          if (dr) chk(tag, "pixel data", cap_d[k], col);
        end
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "busy after reset", 32'(busy), 32'd0);
    chk("R11", "src_ready after reset", 32'(src_ready), 32'd0);
    chk("R11", "out_valid after reset", 32'(out_valid), 32'd0);
    // R3 R5 R6 opaque, width not a multiple of 8
    run_blit("R6", 2'd0, 0, 0, 0, 0, 13, 3, 0, 0);
    // R1 R2 three-byte pixels
    run_blit("R2", 2'd2, 0, 0, 0, 0, 8, 2, 0, 0);
    // R4 transparent foreground
    run_blit("R4", 2'd1, 1, 0, 0, 0, 9, 2, 0, 0);
    // R4 transparent inverted, four-byte pixels
    run_blit("R4", 2'd3, 1, 1, 0, 0, 11, 2, 0, 0);
    // R3 invert ignored in opaque mode
    run_blit("R3", 2'd1, 0, 1, 0, 0, 7, 2, 0, 0);
    // R7 double-word padding
    run_blit("R7", 2'd0, 0, 0, 0, 1, 10, 2, 0, 0);
    run_blit("R7", 2'd1, 1, 0, 0, 1, 40, 2, 0, 0);
    // R8 tile wrap in both directions
    run_blit("R8", 2'd1, 0, 0, 1, 0, 12, 10, 0, 0);
    run_blit("R8", 2'd2, 1, 1, 1, 0, 9, 9, 1, 0);
    // R10 source gaps
    run_blit("R10", 2'd0, 0, 0, 0, 0, 17, 3, 1, 0);
    // R9 start while busy
    run_blit("R9", 2'd1, 0, 0, 0, 0, 20, 3, 0, 1);
    $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule